// File: doc/BRIEF.md
# Extended Accumulator Subtract Unit

This block is the subtract execution stage of a 16-bit fixed-point signal processor. It owns a small operand store made of two wide accumulators (A and B, each a 4-bit guard field over two 16-bit words) and three 16-bit data registers (X0, Y0, Y1). A legal subtract request names a source and a destination. The block aligns the two operands, subtracts the source from the destination, writes the difference back into the destination, and updates the carry, negative, zero and overflow flags, all in one clock.

Two widths of operation exist. With an accumulator as destination, the subtract is 36 bits wide. A 16-bit source is moved into the upper word of a 32-bit value with a zero lower word, then sign extended to 36 bits. It therefore acts on the middle word of the accumulator, and borrows ripple up into the guard field. The Y1:Y0 pair can serve as one sign-extended 32-bit source. With a 16-bit register as destination, the subtract is 16 bits wide. An accumulator source then supplies only its signed middle word. The same arithmetic serves integer and fractional two's-complement data.

A load port writes any register, and a combinational read port exposes any register. These two ports are how the surrounding pipeline, and the bench, put values in and take them out.

Top module: `acc_sub_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, all five registers read as zero, all four flags are 0 and done is 0.
- R2: Register codes are A=0, B=1, X0=2, Y0=3, Y1=4, and Y1:Y0 pair=5. A load writes the full 36 bits into an accumulator, bits 15:0 into a word register, and bits 31:16 into Y1 with bits 15:0 into Y0 for code 5. Word registers read back zero-extended, and code 5 reads back as {4'b0, Y1, Y0}.
- R3: With an accumulator destination and X0, Y0 or Y1 as source, the result is dst − sext36({src, 16'h0000}). For example, A=0x0_0058_1234 minus X0=0x0003 gives A=0x0_0055_1234, and a borrow out of the middle word reaches bits 35:32.
- R4: With an accumulator destination and code 5 as source, the result is dst − sext36({Y1, Y0}).
- R5: With an accumulator as both source and destination, a full 36-bit subtract is done.
- R6: With X0, Y0 or Y1 as destination, a 16-bit subtract is done. An accumulator source supplies only bits 31:16. No register other than the destination changes.
- R7: flag_c is the unsigned borrow of the active width: 1 when dst < src taken as unsigned 36-bit (accumulator destination) or 16-bit (word destination) operands.
- R8: flag_n is the result's top bit, flag_z is set when the result is all zero, and flag_v is set on two's-complement overflow, each taken on the active width.
- R9: done is high for exactly the one cycle in which the written result is first visible on the read port. The flags change only in that cycle and otherwise hold.
- R10: A request with destination code 5, 6 or 7, source code 6 or 7, or source code 5 with a word destination is ignored: no register or flag changes, and done stays 0.
- R11: When a legal request and a load arrive in the same cycle, the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Register code to load |
| ld_data | input | 36 | Load value |
| start | input | 1 | Subtract request strobe |
| src_sel | input | 3 | Source register code |
| dst_sel | input | 3 | Destination register code |
| rd_sel | input | 3 | Register code to read |
| rd_data | output | 36 | Selected register, zero-extended |
| done | output | 1 | One-cycle result-written pulse |
| flag_c | output | 1 | Borrow of the last subtract |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench builds the unit with its default widths: 16-bit words and a 4-bit guard field. This keeps a 36-bit difference inside a 64-bit bench integer, so a plain signed reference can compute every result, borrow and overflow. The narrow guard field means a few chained borrows reach bits 35:32 and the 36-bit overflow point. Directed and seeded random mixes reach both of these, as well as the word-mode sign boundary at 0x8000.

// File: rtl/acc_sub_pkg.sv
// Package: register codes and code classification shared by the subtract unit.
// Assumes a 3-bit register code everywhere.
package acc_sub_pkg;
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_A  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_B  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_X0 = 3'd2;
    localparam logic [SEL_W-1:0] SEL_Y0 = 3'd3;
    localparam logic [SEL_W-1:0] SEL_Y1 = 3'd4;
    localparam logic [SEL_W-1:0] SEL_YP = 3'd5;

    // True for the two accumulator codes.
    function automatic logic is_acc(input logic [SEL_W-1:0] s);
        return (s == SEL_A) || (s == SEL_B);
    endfunction

    // True for the three 16-bit register codes.
    function automatic logic is_word(input logic [SEL_W-1:0] s);
        return (s == SEL_X0) || (s == SEL_Y0) || (s == SEL_Y1);
    endfunction
endpackage

// File: rtl/acc_sub_regfile.sv
// Operand store: two accumulators plus X0, Y0, Y1.
// A write-back has priority over a load in the same cycle; the read port is combinational.
module acc_sub_regfile
    import acc_sub_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int EXT_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [SEL_W-1:0]     ld_sel,
    input  logic [EXT_W+2*WORD_W-1:0] ld_data,
    input  logic                 wb_en,
    input  logic [SEL_W-1:0]     wb_sel,
    input  logic [EXT_W+2*WORD_W-1:0] wb_data,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic [EXT_W+2*WORD_W-1:0] rd_data,
    output logic [EXT_W+2*WORD_W-1:0] a_q,
    output logic [EXT_W+2*WORD_W-1:0] b_q,
    output logic [WORD_W-1:0]    x0_q,
    output logic [WORD_W-1:0]    y0_q,
    output logic [WORD_W-1:0]    y1_q
);
    localparam int ACC_W = EXT_W + 2*WORD_W;
    localparam int PAD_W = ACC_W - WORD_W;

    // Register update: reset, then write-back, else load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            x0_q <= '0;
            y0_q <= '0;
            y1_q <= '0;
        end else if (wb_en) begin
            case (wb_sel)
                SEL_A:   a_q  <= wb_data;
                SEL_B:   b_q  <= wb_data;
                SEL_X0:  x0_q <= wb_data[WORD_W-1:0];
                SEL_Y0:  y0_q <= wb_data[WORD_W-1:0];
                SEL_Y1:  y1_q <= wb_data[WORD_W-1:0];
                default: ;
            endcase
        end else if (ld_en) begin
            case (ld_sel)
                SEL_A:   a_q  <= ld_data;
                SEL_B:   b_q  <= ld_data;
                SEL_X0:  x0_q <= ld_data[WORD_W-1:0];
                SEL_Y0:  y0_q <= ld_data[WORD_W-1:0];
                SEL_Y1:  y1_q <= ld_data[WORD_W-1:0];
                SEL_YP: begin
                    y1_q <= ld_data[2*WORD_W-1:WORD_W];
                    y0_q <= ld_data[WORD_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // Read mux: word registers are zero-extended.
    always_comb begin
        case (rd_sel)
            SEL_A:   rd_data = a_q;
            SEL_B:   rd_data = b_q;
            SEL_X0:  rd_data = {{PAD_W{1'b0}}, x0_q};
            SEL_Y0:  rd_data = {{PAD_W{1'b0}}, y0_q};
            SEL_Y1:  rd_data = {{PAD_W{1'b0}}, y1_q};
            SEL_YP:  rd_data = {{EXT_W{1'b0}}, y1_q, y0_q};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/acc_sub_align.sv
// Operand alignment: picks minuend and subtrahend and the operating width.
// Word-mode operands are placed sign-extended in the low bits; only the low word is used then.
module acc_sub_align
    import acc_sub_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int EXT_W  = 4
) (
    input  logic [SEL_W-1:0]     src_sel,
    input  logic [SEL_W-1:0]     dst_sel,
    input  logic [EXT_W+2*WORD_W-1:0] a_q,
    input  logic [EXT_W+2*WORD_W-1:0] b_q,
    input  logic [WORD_W-1:0]    x0_q,
    input  logic [WORD_W-1:0]    y0_q,
    input  logic [WORD_W-1:0]    y1_q,
    output logic                 legal,
    output logic                 word_mode,
    output logic [EXT_W+2*WORD_W-1:0] min_op,
    output logic [EXT_W+2*WORD_W-1:0] sub_op
);
    localparam int ACC_W = EXT_W + 2*WORD_W;
    localparam int PAD_W = ACC_W - WORD_W;

    logic [WORD_W-1:0]   src_word;
    logic [WORD_W-1:0]   dst_word;
    logic [2*WORD_W-1:0] src_long;

    // Legality and width selection from the two codes.
    always_comb begin
        word_mode = is_word(dst_sel);
        legal     = (is_acc(dst_sel) && (src_sel <= SEL_YP)) ||
                    (word_mode && (src_sel <= SEL_Y1));
    end

    // 16-bit view of the source: accumulators give their middle word.
    always_comb begin
        case (src_sel)
            SEL_A:   src_word = a_q[2*WORD_W-1:WORD_W];
            SEL_B:   src_word = b_q[2*WORD_W-1:WORD_W];
            SEL_X0:  src_word = x0_q;
            SEL_Y0:  src_word = y0_q;
            SEL_Y1:  src_word = y1_q;
            default: src_word = '0;
        endcase
    end

    // 16-bit view of a word destination.
    always_comb begin
        case (dst_sel)
            SEL_X0:  dst_word = x0_q;
            SEL_Y0:  dst_word = y0_q;
            default: dst_word = y1_q;
        endcase
    end

    // 32-bit view of a word or pair source, before sign extension.
    always_comb begin
        if (src_sel == SEL_YP) src_long = {y1_q, y0_q};
        else                   src_long = {src_word, {WORD_W{1'b0}}};
    end

    // Operand placement for the chosen width.
    always_comb begin
        if (word_mode) begin
            min_op = {{PAD_W{dst_word[WORD_W-1]}}, dst_word};
            sub_op = {{PAD_W{src_word[WORD_W-1]}}, src_word};
        end else begin
            min_op = (dst_sel == SEL_B) ? b_q : a_q;
            if (src_sel == SEL_A)      sub_op = a_q;
            else if (src_sel == SEL_B) sub_op = b_q;
            else                       sub_op = {{EXT_W{src_long[2*WORD_W-1]}}, src_long};
        end
    end
endmodule

// File: rtl/acc_sub_core.sv
// Subtractor and flag logic for either the full accumulator width or one word.
// Assumes operands already aligned; in word mode only the low word is meaningful.
module acc_sub_core #(
    parameter int WORD_W = 16,
    parameter int EXT_W  = 4
) (
    input  logic                 word_mode,
    input  logic [EXT_W+2*WORD_W-1:0] min_op,
    input  logic [EXT_W+2*WORD_W-1:0] sub_op,
    output logic [EXT_W+2*WORD_W-1:0] result,
    output logic                 c_out,
    output logic                 n_out,
    output logic                 z_out,
    output logic                 v_out
);
    localparam int ACC_W = EXT_W + 2*WORD_W;
    localparam int PAD_W = ACC_W - WORD_W;

    logic [ACC_W:0]  diff_full;
    logic [WORD_W:0] diff_word;

    // Both widths are subtracted with one extra bit that catches the borrow.
    always_comb begin
        diff_full = {1'b0, min_op} - {1'b0, sub_op};
        diff_word = {1'b0, min_op[WORD_W-1:0]} - {1'b0, sub_op[WORD_W-1:0]};
    end

    // Result and flags for the active width.
    always_comb begin
        if (word_mode) begin
            result = {{PAD_W{diff_word[WORD_W-1]}}, diff_word[WORD_W-1:0]};
            c_out  = diff_word[WORD_W];
            n_out  = diff_word[WORD_W-1];
            z_out  = (diff_word[WORD_W-1:0] == '0);
            v_out  = (min_op[WORD_W-1] != sub_op[WORD_W-1]) &&
                     (diff_word[WORD_W-1] != min_op[WORD_W-1]);
        end else begin
            result = diff_full[ACC_W-1:0];
            c_out  = diff_full[ACC_W];
            n_out  = diff_full[ACC_W-1];
            z_out  = (diff_full[ACC_W-1:0] == '0);
            v_out  = (min_op[ACC_W-1] != sub_op[ACC_W-1]) &&
                     (diff_full[ACC_W-1] != min_op[ACC_W-1]);
        end
    end
endmodule

// File: rtl/acc_sub_unit.sv
// Top: one-cycle subtract with write-back, flags and a done pulse.
// Assumes requests and loads are synchronous to clk; illegal requests are dropped.
module acc_sub_unit
    import acc_sub_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int EXT_W  = 4,
    localparam int ACC_W = EXT_W + 2*WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [2:0]       ld_sel,
    input  logic [ACC_W-1:0] ld_data,
    input  logic             start,
    input  logic [2:0]       src_sel,
    input  logic [2:0]       dst_sel,
    input  logic [2:0]       rd_sel,
    output logic [ACC_W-1:0] rd_data,
    output logic             done,
    output logic             flag_c,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v
);
    logic [ACC_W-1:0]  a_q, b_q, min_op, sub_op, result;
    logic [WORD_W-1:0] x0_q, y0_q, y1_q;
    logic legal, word_mode, go, c_nx, n_nx, z_nx, v_nx;

    assign go = start && legal;

    acc_sub_regfile #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .wb_en(go), .wb_sel(dst_sel), .wb_data(result),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .a_q(a_q), .b_q(b_q), .x0_q(x0_q), .y0_q(y0_q), .y1_q(y1_q)
    );

    acc_sub_align #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_align (
        .src_sel(src_sel), .dst_sel(dst_sel),
        .a_q(a_q), .b_q(b_q), .x0_q(x0_q), .y0_q(y0_q), .y1_q(y1_q),
        .legal(legal), .word_mode(word_mode),
        .min_op(min_op), .sub_op(sub_op)
    );

    acc_sub_core #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_core (
        .word_mode(word_mode), .min_op(min_op), .sub_op(sub_op),
        .result(result), .c_out(c_nx), .n_out(n_nx), .z_out(z_nx), .v_out(v_nx)
    );

    // Done pulse and flag capture on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            flag_c <= 1'b0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
        end else begin
            done <= go;
            if (go) begin
                flag_c <= c_nx;
                flag_n <= n_nx;
                flag_z <= z_nx;
                flag_v <= v_nx;
            end
        end
    end
endmodule

// File: rtl/acc_sub_chk.sv
// Checker for acc_sub_unit: temporal properties on ports and register state.
// Bound into every instance of the top module.
module acc_sub_chk
    import acc_sub_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int EXT_W  = 4,
    localparam int ACC_W = EXT_W + 2*WORD_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             ld_en,
    input logic [2:0]       src_sel,
    input logic [2:0]       dst_sel,
    input logic             done,
    input logic             flag_c,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_v,
    input logic [ACC_W-1:0] a_q,
    input logic [ACC_W-1:0] b_q,
    input logic [WORD_W-1:0] x0_q,
    input logic [WORD_W-1:0] y0_q,
    input logic [WORD_W-1:0] y1_q
);
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));  // R9
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start) |-> $stable({flag_c, flag_n, flag_z, flag_v}));  // R9
    AST_REGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start) && !$past(ld_en)) |->
        ($stable(a_q) && $stable(b_q) && $stable(x0_q) && $stable(y0_q) && $stable(y1_q)));  // R2
    AST_NEG_ON_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(dst_sel) == SEL_A) |-> (flag_n == a_q[ACC_W-1]));  // R8
    AST_ZERO_ON_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(dst_sel) == SEL_B) |-> (flag_z == (b_q == '0)));  // R8
    AST_WORD_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_word($past(dst_sel))) |-> ($stable(a_q) && $stable(b_q)));  // R6
    AST_ILLEGAL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && ($past(dst_sel) >= SEL_YP || $past(src_sel) > SEL_YP)) |-> !done);  // R10
endmodule

bind acc_sub_unit acc_sub_chk #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_en(ld_en),
    .src_sel(src_sel), .dst_sel(dst_sel), .done(done),
    .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .a_q(a_q), .b_q(b_q), .x0_q(x0_q), .y0_q(y0_q), .y1_q(y1_q)
);

// File: tb/acc_sub_unit_test.sv
module acc_sub_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic [35:0] ld_data = '0;
    logic        start = 1'b0;
    logic [2:0]  src_sel = '0;
    logic [2:0]  dst_sel = '0;
    logic [2:0]  rd_sel = '0;
    logic [35:0] rd_data;
    logic        done, flag_c, flag_n, flag_z, flag_v;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model
    logic [35:0] m_a = '0, m_b = '0;
    logic [15:0] m_x0 = '0, m_y0 = '0, m_y1 = '0;
    logic m_c = 0, m_n = 0, m_z = 0, m_v = 0;

    localparam longint LIM36 = 64'sd34359738368;

    acc_sub_unit uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .start(start), .src_sel(src_sel), .dst_sel(dst_sel), .rd_sel(rd_sel),
        .rd_data(rd_data), .done(done), .flag_c(flag_c), .flag_n(flag_n),
        .flag_z(flag_z), .flag_v(flag_v)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic longint sx36(input logic [35:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [35:0] model_read(input logic [2:0] s);
        case (s)
            3'd0: return m_a;
            3'd1: return m_b;
            3'd2: return {20'h0, m_x0};
            3'd3: return {20'h0, m_y0};
            3'd4: return {20'h0, m_y1};
            3'd5: return {4'h0, m_y1, m_y0};
            default: return '0;
        endcase
    endfunction

    task automatic check_regs(input string req);
        for (int s = 0; s < 8; s++) begin
            rd_sel = 3'(s);
            #1;
            chk(rd_data === model_read(3'(s)), req, $sformatf("reg code %0d", s),
                64'(rd_data), 64'(model_read(3'(s))));
        end
    endtask

    task automatic check_flags(input string req);
        chk({flag_c, flag_n, flag_z, flag_v} === {m_c, m_n, m_z, m_v}, req, "flags CNZV",
            64'({flag_c, flag_n, flag_z, flag_v}), 64'({m_c, m_n, m_z, m_v}));
    endtask

    task automatic model_load(input logic [2:0] s, input logic [35:0] v);
        case (s)
            3'd0: m_a = v;
            3'd1: m_b = v;
            3'd2: m_x0 = v[15:0];
            3'd3: m_y0 = v[15:0];
            3'd4: m_y1 = v[15:0];
            3'd5: begin m_y1 = v[31:16]; m_y0 = v[15:0]; end
            default: ;
        endcase
    endtask

    task automatic load(input logic [2:0] s, input logic [35:0] v);
        @(negedge clk);
        ld_en = 1; ld_sel = s; ld_data = v;
        @(negedge clk);
        ld_en = 0;
        model_load(s, v);
    endtask

    // Reference: returns 1 when the request is legal and updates the model.
    function automatic bit model_sub(input logic [2:0] src, input logic [2:0] dst);
        longint mv, sv, d;
        logic [63:0] um, us, dd;
        logic [15:0] w;
        bit acc_dst = (dst <= 3'd1);
        bit word_dst = (dst >= 3'd2 && dst <= 3'd4);
        if (!((acc_dst && src <= 3'd5) || (word_dst && src <= 3'd4))) return 0;
        if (acc_dst) begin
            mv = sx36(dst == 3'd0 ? m_a : m_b);
            case (src)
                3'd0: sv = sx36(m_a);
                3'd1: sv = sx36(m_b);
                3'd2: sv = longint'($signed(m_x0)) * 65536;
                3'd3: sv = longint'($signed(m_y0)) * 65536;
                3'd4: sv = longint'($signed(m_y1)) * 65536;
                default: sv = longint'($signed({m_y1, m_y0}));
            endcase
            d = mv - sv;
            dd = 64'(d);
            um = 64'(mv) & 64'hF_FFFF_FFFF;
            us = 64'(sv) & 64'hF_FFFF_FFFF;
            m_c = (um < us);
            m_v = (d >= LIM36) || (d < -LIM36);
            m_n = dd[35];
            m_z = (dd[35:0] == 36'h0);
            if (dst == 3'd0) m_a = dd[35:0]; else m_b = dd[35:0];
        end else begin
            w = (dst == 3'd2) ? m_x0 : (dst == 3'd3) ? m_y0 : m_y1;
            mv = longint'($signed(w));
            case (src)
                3'd0: sv = longint'($signed(m_a[31:16]));
                3'd1: sv = longint'($signed(m_b[31:16]));
                3'd2: sv = longint'($signed(m_x0));
                3'd3: sv = longint'($signed(m_y0));
                default: sv = longint'($signed(m_y1));
            endcase
            d = mv - sv;
            dd = 64'(d);
            m_c = (64'(mv) & 64'hFFFF) < (64'(sv) & 64'hFFFF);
            m_v = (d > 32767) || (d < -32768);
            m_n = dd[15];
            m_z = (dd[15:0] == 16'h0);
            case (dst)
                3'd2: m_x0 = dd[15:0];
                3'd3: m_y0 = dd[15:0];
                default: m_y1 = dd[15:0];
            endcase
        end
        return 1;
    endfunction

    task automatic do_sub(input logic [2:0] src, input logic [2:0] dst, input string req);
        bit ok;
        @(negedge clk);
        start = 1; src_sel = src; dst_sel = dst;
        ok = model_sub(src, dst);
        @(negedge clk);
        start = 0;
        chk(done === ok, "R9", $sformatf("%s done src=%0d dst=%0d", req, src, dst),
            64'(done), 64'(ok));
        check_flags(req);
        check_regs(req);
    endtask

    function automatic logic [15:0] rnd_word();
        case ($urandom_range(0, 5))
            0: return 16'h0000;
            1: return 16'h7FFF;
            2: return 16'h8000;
            3: return 16'hFFFF;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic logic [35:0] rnd_acc();
        logic [31:0] lo;
        lo = {rnd_word(), rnd_word()};
        if ($urandom_range(0, 2) == 0) return {4'($urandom), lo};
        return {{4{lo[31]}}, lo};
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: registers, flags and done during and right after reset
        check_flags("R1");
        chk(done === 1'b0, "R1", "done in reset", 64'(done), 64'h0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_regs("R1");
        check_flags("R1");
        chk(done === 1'b0, "R1", "done after reset", 64'(done), 64'h0);

        // R2: load and read back every code
        load(3'd0, 36'h9_1234_5678);
        load(3'd1, 36'h0_0BAD_F00D);
        load(3'd2, 36'hF_FFFF_ABCD);
        load(3'd5, 36'h7_8001_0002);
        check_regs("R2");
        load(3'd3, 36'h0_0000_1111);
        load(3'd4, 36'h0_0000_2222);
        check_regs("R2");

        // R3: worked example and borrow into guard bits
        load(3'd0, 36'h0_0058_1234);
        load(3'd2, 36'h3);
        do_sub(3'd2, 3'd0, "R3");
        chk(m_a === 36'h0_0055_1234, "R3", "example value", 64'(m_a), 64'h0_0055_1234);
        load(3'd0, 36'h0);
        load(3'd2, 36'h1);
        do_sub(3'd2, 3'd0, "R3 R7");
        chk(flag_c === 1'b1, "R7", "borrow from zero", 64'(flag_c), 64'h1);

        // R4: pair source subtracts -1 from the low part
        load(3'd5, 36'h0_FFFF_FFFF);
        load(3'd1, 36'h0_0000_FFFF);
        do_sub(3'd5, 3'd1, "R4");

        // R5: accumulator from accumulator, overflow at 36 bits
        load(3'd0, 36'h8_0000_0000);
        load(3'd1, 36'h0_0000_0001);
        do_sub(3'd1, 3'd0, "R5 R8");
        chk(flag_v === 1'b1, "R8", "36-bit overflow", 64'(flag_v), 64'h1);
        do_sub(3'd0, 3'd0, "R5 R8");

        // R6: word mode with accumulator middle part 0x8000
        load(3'd0, 36'hF_8000_1234);
        load(3'd2, 36'h5);
        do_sub(3'd0, 3'd2, "R6 R8");
        chk(flag_v === 1'b1, "R8", "16-bit overflow", 64'(flag_v), 64'h1);
        do_sub(3'd3, 3'd3, "R6 R8");
        chk(flag_z === 1'b1, "R8", "word zero", 64'(flag_z), 64'h1);

        // R9: flags hold across idle cycles
        repeat (3) @(negedge clk);
        check_flags("R9");
        chk(done === 1'b0, "R9", "done idle", 64'(done), 64'h0);

        // R10: illegal requests
        do_sub(3'd0, 3'd5, "R10");
        do_sub(3'd6, 3'd0, "R10");
        do_sub(3'd5, 3'd2, "R10");
        do_sub(3'd1, 3'd7, "R10");

        // R11: legal request and load together
        @(negedge clk);
        start = 1; src_sel = 3'd2; dst_sel = 3'd1;
        ld_en = 1; ld_sel = 3'd4; ld_data = 36'h0_0000_BEEF;
        void'(model_sub(3'd2, 3'd1));
        @(negedge clk);
        start = 0; ld_en = 0;
        check_regs("R11");

        // random mix
        for (int i = 0; i < 500; i++) begin
            if ($urandom_range(0, 1) == 0) begin
                logic [2:0] s;
                s = 3'($urandom_range(0, 5));
                load(s, (s <= 3'd1) ? rnd_acc() : {4'h0, rnd_word(), rnd_word()});
            end
            if ($urandom_range(0, 7) == 0)
                do_sub(3'($urandom), 3'($urandom), "R10 R7 R8");
            else
                do_sub(3'($urandom_range(0, 5)), 3'($urandom_range(0, 4)), "R3 R4 R5 R6 R7 R8");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule